// File: doc/BRIEF.md
# Overlapped Register Window File

This block is a register file for a processor that passes procedure arguments in registers. It holds 64 physical words. Sixteen of them form a global bank that every procedure addresses the same way. The other 48 form a ring of overlapping windows. A window pointer selects the window that is current, and each logical register number is turned into a physical index through that pointer. The windows overlap, so the registers a caller fills with outgoing arguments are the same storage the callee reads as its incoming arguments. No data is copied on a call or on a return.

Logical numbers 0 to 15 name the globals. Numbers 16 to 23 name the current window. Numbers 24 to 31 name nothing. The file has two combinational read ports and one clocked write port. A call strobe moves the window one step forward and a return strobe moves it one step back. The block raises a one-cycle overflow or underflow flag when software must save windows to memory or restore them from memory. It does not move any data to or from memory itself.

Top module: `rwin_regfile`

## Requirements
- R1: After reset every mapped logical register reads 0, both flags are low, and the window pointer is 0.
- R2: Logical registers 0–15 always reach the same physical word, whatever the window pointer. A value written there is seen unchanged after any calls and returns.
- R3: In the current window, logical 16–17 are the incoming arguments, 18–21 the locals and 22–23 the outgoing arguments. Logical l in window w maps to physical 16 + ((6·w + l − 16) mod 48). There are 8 windows. A windowed register never maps into the global bank.
- R4: A call (call_i=1, ret_i=0) advances the pointer by one at the next edge. Values the caller wrote to logical 22/23 then read from logical 16/17. A return (ret_i=1, call_i=0) moves the pointer back, and values the callee wrote to 16/17 then read from the caller's 22/23.
- R5: A callee's locals are distinct storage from the caller's locals. The caller's locals are intact after the return.
- R6: The pointer wraps modulo 8. After 8 calls the logical registers map to the same storage as before. Window 7's outgoing arguments are window 0's incoming arguments.
- R7: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value is visible after the edge.
- R8: If call_i and ret_i are both 1 in one cycle, the strobes have no effect: the pointer and flags stay as they were.
- R9: The number of live frames beyond the oldest is capped at 6. A call made at that depth raises ovf_o for the one cycle after the edge. The pointer still advances and the depth stays at 6.
- R10: A return made at depth 0 raises unf_o for the one cycle after the edge, and the pointer still moves back.
- R11: Logical registers 24–31 read as 0, and writes to them change no register.
- R12: A write in the same cycle as a call or return uses the window that was current before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr_a | input | 5 | Logical register for read port A |
| rd_data_a | output | 32 | Read data A (combinational) |
| rd_addr_b | input | 5 | Logical register for read port B |
| rd_data_b | output | 32 | Read data B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register to write |
| wr_data | input | 32 | Write data |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| ovf_o | output | 1 | Window overflow pulse |
| unf_o | output | 1 | Window underflow pulse |

## Verification
The bench checks that arguments travel both ways through the overlap. A design with an off-by-one stride or with the overlap on the wrong side would show the caller's arguments in the callee's locals, or in nothing at all. It drives the pointer around the full ring of 8 windows and checks the wrap. A modulo error there shows up as window 7's outputs landing outside window 0's inputs. It checks the depth cap and the floor, where a design that froze the pointer on overflow, or never flagged it, would be caught. It also checks a write in the same cycle as a call, simultaneous strobes and unmapped register numbers. A design that translated with the next window, moved on conflicting strobes, or aliased numbers 24–31 onto real storage would fail those checks.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int DEF_NUM_PHYS   = 64;
  localparam int DEF_NUM_GLOBAL = 16;
  localparam int DEF_WIN_ARG    = 2;  // incoming == outgoing argument count
  localparam int DEF_WIN_LOCAL  = 4;
  localparam int DEF_DATA_W     = 32;

  typedef enum logic [1:0] {
    WIN_HOLD = 2'd0,
    WIN_CALL = 2'd1,
    WIN_RET  = 2'd2
  } win_op_e;
endpackage

// File: rtl/rwin_xlate.sv
module rwin_xlate #(
  parameter int NUM_GLOBAL = 16,
  parameter int WIN_ARG    = 2,
  parameter int WIN_LOCAL  = 4,
  parameter int NUM_WIN    = 8,
  parameter int LW         = 5,
  parameter int PW         = 3,
  parameter int IW         = 6
) (
  input  logic [LW-1:0] lreg_i,
  input  logic [PW-1:0] cwp_i,
  output logic [IW-1:0] pidx_o,
  output logic          valid_o
);
  localparam int STRIDE = WIN_LOCAL + WIN_ARG;
  localparam int WIN_SZ = 2 * WIN_ARG + WIN_LOCAL;
  localparam int REGION = STRIDE * NUM_WIN;
  localparam int LREGS  = NUM_GLOBAL + WIN_SZ;

  // returns {valid, physical index}
  function automatic logic [IW:0] map_lreg(input logic [LW-1:0] l, input logic [PW-1:0] w);
    int li;
    int wi;
    int off;
    logic [IW:0] r;
    li = int'(l);
    wi = int'(w);
    r  = '0;
    if (li < NUM_GLOBAL) begin
      r = {1'b1, IW'(li)};
    end else if (li < LREGS) begin
      off = wi * STRIDE + (li - NUM_GLOBAL);
      if (off >= REGION) off = off - REGION;
      r = {1'b1, IW'(NUM_GLOBAL + off)};
    end
    return r;
  endfunction

  logic [IW:0] mapped;
  assign mapped  = map_lreg(lreg_i, cwp_i);
  assign pidx_o  = mapped[IW-1:0];
  assign valid_o = mapped[IW];
endmodule

// File: rtl/rwin_ptr.sv
module rwin_ptr
  import rwin_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int PW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  output logic [PW-1:0] cwp_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam int MAX_DEPTH = NUM_WIN - 2;
  localparam int DPW       = $clog2(NUM_WIN);

  win_op_e        op;
  logic [PW-1:0]  cwp_q;
  logic [DPW-1:0] depth_q;
  logic           ovf_q, unf_q;
  logic           at_cap, at_floor;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p, input win_op_e o);
    logic [PW-1:0] r;
    r = p;
    if (o == WIN_CALL) r = (int'(p) == NUM_WIN - 1) ? '0 : p + 1'b1;
    else if (o == WIN_RET) r = (p == '0) ? PW'(NUM_WIN - 1) : p - 1'b1;
    return r;
  endfunction

  always_comb begin
    unique case ({call_i, ret_i})
      2'b10:   op = WIN_CALL;
      2'b01:   op = WIN_RET;
      default: op = WIN_HOLD;
    endcase
  end

  assign at_cap   = (int'(depth_q) == MAX_DEPTH);
  assign at_floor = (depth_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp_q   <= '0;
      depth_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      cwp_q <= step_ptr(cwp_q, op);
      ovf_q <= (op == WIN_CALL) && at_cap;
      unf_q <= (op == WIN_RET) && at_floor;
      if (op == WIN_CALL && !at_cap)   depth_q <= depth_q + 1'b1;
      if (op == WIN_RET  && !at_floor) depth_q <= depth_q - 1'b1;
    end
  end

  assign cwp_o = cwp_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  AST_OVF_NEEDS_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $past(call_i && !ret_i)); // R9
  AST_UNF_NEEDS_RET: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |-> $past(ret_i && !call_i)); // R10
  AST_DEPTH_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    int'(depth_q) <= MAX_DEPTH); // R9
  AST_BOTH_STROBES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |=> ($stable(cwp_q) && $stable(depth_q))); // R8
  AST_CALL_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i) |=> (cwp_q != $past(cwp_q))); // R4
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int NUM_PHYS = 64,
  parameter int DATA_W   = 32,
  parameter int IW       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IW-1:0]     widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IW-1:0]     ridx_a_i,
  input  logic [IW-1:0]     ridx_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem_q [NUM_PHYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[ridx_a_i];
  assign rdata_b_o = mem_q[ridx_b_i];
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwin_pkg::*;
#(
  parameter int NUM_PHYS   = DEF_NUM_PHYS,
  parameter int NUM_GLOBAL = DEF_NUM_GLOBAL,
  parameter int WIN_ARG    = DEF_WIN_ARG,
  parameter int WIN_LOCAL  = DEF_WIN_LOCAL,
  parameter int DATA_W     = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [4:0]        rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [4:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              call_i,
  input  logic              ret_i,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int STRIDE  = WIN_LOCAL + WIN_ARG;
  localparam int WIN_SZ  = 2 * WIN_ARG + WIN_LOCAL;
  localparam int NUM_WIN = (NUM_PHYS - NUM_GLOBAL) / STRIDE;
  localparam int LREGS   = NUM_GLOBAL + WIN_SZ;
  localparam int LW      = 5;
  localparam int PW      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int IW      = $clog2(NUM_PHYS);
  localparam int NPORT   = 3;  // 0: read A, 1: read B, 2: write

  logic [PW-1:0]     cwp;
  logic [LW-1:0]     port_lreg  [NPORT];
  logic [IW-1:0]     port_pidx  [NPORT];
  logic              port_valid [NPORT];
  logic [DATA_W-1:0] raw_a, raw_b;
  logic              wr_hit;

  assign port_lreg[0] = rd_addr_a;
  assign port_lreg[1] = rd_addr_b;
  assign port_lreg[2] = wr_addr;

  rwin_ptr #(.NUM_WIN(NUM_WIN), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .cwp_o(cwp), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_xlate
    rwin_xlate #(
      .NUM_GLOBAL(NUM_GLOBAL), .WIN_ARG(WIN_ARG), .WIN_LOCAL(WIN_LOCAL),
      .NUM_WIN(NUM_WIN), .LW(LW), .PW(PW), .IW(IW)
    ) u_xlate (
      .lreg_i(port_lreg[p]), .cwp_i(cwp),
      .pidx_o(port_pidx[p]), .valid_o(port_valid[p])
    );
  end

  assign wr_hit = wr_en && port_valid[2];

  rwin_store #(.NUM_PHYS(NUM_PHYS), .DATA_W(DATA_W), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we_i(wr_hit), .widx_i(port_pidx[2]), .wdata_i(wr_data),
    .ridx_a_i(port_pidx[0]), .ridx_b_i(port_pidx[1]),
    .rdata_a_o(raw_a), .rdata_b_o(raw_b)
  );

  assign rd_data_a = port_valid[0] ? raw_a : '0;
  assign rd_data_b = port_valid[1] ? raw_b : '0;

  AST_WIN_OUTSIDE_GLOBALS: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr_a) >= NUM_GLOBAL && port_valid[0]) |-> (int'(port_pidx[0]) >= NUM_GLOBAL)); // R3
  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr_b) >= LREGS) |-> (rd_data_b == '0)); // R11
  AST_NO_BOTH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o)); // R9
endmodule

// File: tb/rwin_regfile_tb.sv
module rwin_regfile_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          port;   // 0 rd A, 1 rd B, 2 ovf, 3 unf
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0;
  logic [31:0] rd_data_a, rd_data_b;
  logic        ovf_o, unf_o;

  item_t item_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rwin_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .call_i(call_i), .ret_i(ret_i), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // monitor: compare all queued expectations mid-cycle
  always @(negedge clk) begin
    while (item_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = item_q.pop_front();
      case (it.port)
        0:       act = rd_data_a;
        1:       act = rd_data_b;
        2:       act = {31'd0, ovf_o};
        default: act = {31'd0, unf_o};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    wr_en = 1'b0; call_i = 1'b0; ret_i = 1'b0;
  endtask
  task automatic exp_a(input logic [4:0] a, input logic [31:0] e, input string t);
    item_t it; rd_addr_a = a; it.port = 0; it.exp = e; it.tag = t; item_q.push_back(it);
  endtask
  task automatic exp_b(input logic [4:0] a, input logic [31:0] e, input string t);
    item_t it; rd_addr_b = a; it.port = 1; it.exp = e; it.tag = t; item_q.push_back(it);
  endtask
  task automatic exp_flags(input logic o, input logic u, input string t);
    item_t it;
    it.port = 2; it.exp = {31'd0, o}; it.tag = t; item_q.push_back(it);
    it.port = 3; it.exp = {31'd0, u}; item_q.push_back(it);
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    exp_a(5'd0, 32'h0, "R1 global 0"); exp_b(5'd23, 32'h0, "R1 window out");
    exp_flags(1'b0, 1'b0, "R1 flags");
    cyc(); // R7 same-cycle write/read returns old value
    wr(5'd5, 32'hA5A5_0005); exp_a(5'd5, 32'h0, "R7 old value");
    cyc(); exp_a(5'd5, 32'hA5A5_0005, "R7 new value"); wr(5'd18, 32'h1111_0018);
    cyc(); wr(5'd22, 32'hCAFE_0022);
    cyc(); wr(5'd23, 32'hCAFE_0023); call_i = 1'b1;          // R12 write with call
    cyc(); // window 1
    exp_a(5'd16, 32'hCAFE_0022, "R4 out->in");
    exp_b(5'd17, 32'hCAFE_0023, "R12 write used old window");
    exp_flags(1'b0, 1'b0, "R9 no ovf at depth 1");
    cyc();
    exp_a(5'd18, 32'h0, "R5 callee local fresh"); exp_b(5'd5, 32'hA5A5_0005, "R2 global in callee");
    wr(5'd16, 32'hBEEF_0016);
    cyc(); ret_i = 1'b1; exp_a(5'd16, 32'hBEEF_0016, "R4 callee sees own write");
    cyc(); // window 0
    exp_a(5'd22, 32'hBEEF_0016, "R4 in->out on return");
    exp_b(5'd18, 32'h1111_0018, "R5 caller local intact");
    exp_flags(1'b0, 1'b0, "R10 no unf at depth 1");
    cyc(); call_i = 1'b1; ret_i = 1'b1;                      // R8
    cyc();
    exp_a(5'd18, 32'h1111_0018, "R8 window unchanged");
    exp_b(5'd22, 32'hBEEF_0016, "R8 outs unchanged");
    exp_flags(1'b0, 1'b0, "R8 no flags");
    cyc(); wr(5'd27, 32'hDEAD_0027); exp_a(5'd27, 32'h0, "R11 unmapped read");
    cyc();
    exp_a(5'd27, 32'h0, "R11 unmapped after write"); exp_b(5'd18, 32'h1111_0018, "R11 no alias");
    // six calls: depth 0 -> 6, window 6
    for (int i = 0; i < 6; i++) begin cyc(); call_i = 1'b1; end
    cyc(); exp_flags(1'b0, 1'b0, "R9 no ovf below cap");
    call_i = 1'b1;                                           // seventh call at cap
    cyc(); // window 7
    exp_flags(1'b1, 1'b0, "R9 ovf pulse");
    wr(5'd22, 32'h7777_0022); call_i = 1'b1;                 // eighth call, wraps
    cyc(); // window 0
    exp_flags(1'b1, 1'b0, "R9 ovf again at cap");
    exp_a(5'd16, 32'h7777_0022, "R6 window 7 out = window 0 in");
    exp_b(5'd18, 32'h1111_0018, "R6 wrap back to window 0");
    cyc(); exp_flags(1'b0, 1'b0, "R9 ovf single cycle");
    exp_a(5'd5, 32'hA5A5_0005, "R2 global after ring");
    // six returns: depth 6 -> 0, window 2
    for (int i = 0; i < 6; i++) begin cyc(); ret_i = 1'b1; end
    cyc(); exp_flags(1'b0, 1'b0, "R10 no unf above floor");
    ret_i = 1'b1;                                            // return at floor
    cyc(); // window 1
    exp_flags(1'b0, 1'b1, "R10 unf pulse");
    exp_a(5'd16, 32'hBEEF_0016, "R10 pointer moved back to window 1");
    exp_b(5'd17, 32'hCAFE_0023, "R3 window 1 in-arg mapping");
    cyc(); exp_flags(1'b0, 1'b0, "R10 unf single cycle");
    cyc();
    done = 1'b1;
    summary();
  end
endmodule